// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a watchdog timer on a small memory-mapped register bus. Software sets an interval code and an enable bit in a mode register. It then has to restart the count before the interval runs out. A restart counts only when the write to the control register carries a 12-bit key together with a go bit, so a write that runs wild is unlikely to keep a failed system alive. A prescaler divides the system clock into half-second ticks, and an expiry counter compares the elapsed ticks with the limit that the interval code selects.

When the count expires, the configured action runs. One choice is a system-reset pulse of fixed length. The other is a sticky interrupt-pending flag, which only a keyed restart clears. A parameter selects one of two register layouts. The default layout keeps control, configuration and mode in three separate words. The alternate layout puts the control word at offset zero and packs configuration and mode into a single word.

Top module: `wdog_keyed`

## Requirements
- R1: A bus write to the control register restarts the interval count from zero only when write data bit 0 is 1 and bits 12:1 equal 0xA57. Such a keyed write also clears the interrupt-pending flag.
- R2: A control write whose key field is not 0xA57, or whose bit 0 is 0, leaves the count running and changes no output.
- R3: The mode interval code selects the expiry time in half-second ticks, where one tick is TICK_CYCLES clock cycles. Code 0x0 gives 1 tick. Codes 0x1 to 0x6 give 2, 4, 6, 8, 10 and 12 ticks. Codes 0x7 to 0xA give 16, 20, 24 and 28 ticks. Codes 0xB to 0xF give 32 ticks. Expiry happens on the clock edge that is ticks×TICK_CYCLES edges after the restart edge, and the count then starts again from zero.
- R4: The count restarts on a mode write that changes the interval code, and on a mode write that takes the enable bit from 0 to 1. A mode write that leaves both unchanged does not restart it. While the block is disabled it neither counts nor expires, and writing all zeros to the mode register disables it.
- R5: When the count expires with the reset action selected, sys_rst_out is high for exactly RST_PULSE cycles, starting in the cycle right after the expiry edge.
- R6: When the count expires with any other action, irq_pend goes to 1 and stays at 1 until a keyed restart.
- R7: In the default layout the control word is at 0x10, the configuration word is at 0x14 and the mode word is at 0x18. The action is configuration bits 1:0, and the value 01 selects reset. The mode enable is bit 0, and the interval code is bits 7:4.
- R8: In the alternate layout the control word is at 0x00. A single word at 0x04 holds the enable in bit 0, the reset select in bit 1 (1 selects reset) and the interval code in bits 6:3.
- R9: A read returns the stored fields on bus_rdata one cycle after the read strobe, with all other bits zero. The control word and unmapped offsets read as zero. bus_rdata holds its value when no read is made.
- R10: After reset the block is disabled, the interval code is 0 and the action is interrupt, so all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| sys_rst_out | output | 1 | System-reset pulse on expiry |
| irq_pend | output | 1 | Sticky interrupt-pending flag |

## Verification
The bench runs both register layouts against a reference that measures elapsed cycles against each deadline. It walks all sixteen interval codes, including the four codes above 0xB, where a design with a short lookup table would expire far too early. Near-miss writes are aimed at the control word: a key off by one, and the correct key with the go bit clear. A design that accepts either would push the expiry later, and the comparison made every cycle would catch it. Mode rewrites that leave the fields unchanged check that no spurious restart occurs. A disabled interval checks that no reset pulse or interrupt leaks out, and an action value of 10 checks that only 01 counts as reset in the default layout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] RELOAD_KEY = 12'hA57;

  // Expiry limit in half-second ticks for a 4-bit interval code.
  function automatic logic [5:0] ticks_for_code(input logic [3:0] code);
    logic [5:0] t;
    case (code)
      4'h0: t = 6'd1;
      4'h1: t = 6'd2;
      4'h2: t = 6'd4;
      4'h3: t = 6'd6;
      4'h4: t = 6'd8;
      4'h5: t = 6'd10;
      4'h6: t = 6'd12;
      4'h7: t = 6'd16;
      4'h8: t = 6'd20;
      4'h9: t = 6'd24;
      4'hA: t = 6'd28;
      default: t = 6'd32;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter bit ALT_LAYOUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic [3:0]        code,
  output logic              rst_sel,
  output logic              kick,
  output logic              restart
);
  localparam logic [ADDR_W-1:0] A_CTRL = ALT_LAYOUT ? ADDR_W'('h00) : ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CFG  = ALT_LAYOUT ? ADDR_W'('h04) : ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_MODE = ALT_LAYOUT ? ADDR_W'('h04) : ADDR_W'('h18);
  localparam int CODE_LSB = ALT_LAYOUT ? 3 : 4;

  logic              en_q;
  logic [3:0]        code_q;
  logic [DATA_W-1:0] rd_val;
  logic              hit_ctrl, hit_cfg, hit_mode;
  logic [3:0]        new_code;
  logic              new_en;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign hit_ctrl = wr && (addr == A_CTRL);
  assign hit_cfg  = wr && (addr == A_CFG);
  assign hit_mode = wr && (addr == A_MODE);
  assign new_code = wdata[CODE_LSB +: 4];
  assign new_en   = wdata[0];

  assign kick    = hit_ctrl && wdata[0] && (wdata[12:1] == RELOAD_KEY);
  assign restart = kick || (hit_mode && ((new_code != code_q) || (new_en && !en_q)));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      code_q <= 4'h0;
    end else if (hit_mode) begin
      en_q   <= new_en;
      code_q <= new_code;
    end
  end

  generate
    if (ALT_LAYOUT) begin : g_packed
      logic sel_q;
      always_ff @(posedge clk) begin
        if (rst)          sel_q <= 1'b0;
        else if (hit_cfg) sel_q <= wdata[1];
      end
      assign rst_sel = sel_q;
      always_comb begin
        rd_val = '0;
        if (addr == A_MODE) begin
          rd_val[0]             = en_q;
          rd_val[1]             = sel_q;
          rd_val[CODE_LSB +: 4] = code_q;
        end
      end
    end else begin : g_split
      logic [1:0] act_q;
      always_ff @(posedge clk) begin
        if (rst)          act_q <= 2'b00;
        else if (hit_cfg) act_q <= wdata[1:0];
      end
      assign rst_sel = (act_q == 2'b01);
      always_comb begin
        rd_val = '0;
        if (addr == A_CFG) rd_val[1:0] = act_q;
        if (addr == A_MODE) begin
          rd_val[0]             = en_q;
          rd_val[CODE_LSB +: 4] = code_q;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

  assign en   = en_q;
  assign code = code_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICK_CYCLES = 12_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt;

  assign tick = run && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (cnt == LAST)     cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic       tick,
  input  logic [3:0] code,
  input  logic       rst_sel,
  input  logic       kick,
  output logic       rst_out,
  output logic       irq
);
  localparam int RW = $clog2(RST_PULSE + 1);

  logic [4:0]    cnt;
  logic [5:0]    lim;
  logic          expire;
  logic [RW-1:0] rst_left;

  assign lim    = ticks_for_code(code);
  assign expire = run && !clear && tick && ({1'b0, cnt} == lim - 6'd1);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (expire)          cnt <= '0;
    else if (tick)            cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         rst_left <= '0;
    else if (expire && rst_sel)      rst_left <= RW'(RST_PULSE);
    else if (rst_left != '0)         rst_left <= rst_left - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     irq <= 1'b0;
    else if (kick)               irq <= 1'b0;
    else if (expire && !rst_sel) irq <= 1'b1;
  end

  assign rst_out = (rst_left != '0);

  assert_restart_zero_R1: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == 5'd0));
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < lim));
  assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == 5'd0));
  assert_rst_follows_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> $past(expire && rst_sel));
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !kick) |=> irq);
  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
    kick |=> !irq);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter bit ALT_LAYOUT  = 1'b0,
  parameter int TICK_CYCLES = 12_000_000,
  parameter int RST_PULSE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_out,
  output logic              irq_pend
);
  logic       en, rst_sel, kick, restart, tick;
  logic [3:0] code;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_LAYOUT(ALT_LAYOUT)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr), .rd(bus_rd),
    .rdata(bus_rdata), .en(en), .code(code), .rst_sel(rst_sel), .kick(kick),
    .restart(restart)
  );

  wdog_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst(rst), .clear(restart), .run(en), .tick(tick)
  );

  wdog_expiry #(.RST_PULSE(RST_PULSE)) u_exp (
    .clk(clk), .rst(rst), .clear(restart), .run(en), .tick(tick), .code(code),
    .rst_sel(rst_sel), .kick(kick), .rst_out(sys_rst_out), .irq(irq_pend)
  );
endmodule

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
  localparam int TK = 4;
  localparam int RP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]  ba [2];
  logic [31:0] bd [2];
  logic        bw [2];
  logic        br [2];
  logic [31:0] q  [2];
  logic        so [2];
  logic        ir [2];

  wdog_keyed #(.ALT_LAYOUT(1'b0), .TICK_CYCLES(TK), .RST_PULSE(RP)) uut (
    .clk(clk), .rst(rst), .bus_addr(ba[0]), .bus_wdata(bd[0]), .bus_wr(bw[0]),
    .bus_rd(br[0]), .bus_rdata(q[0]), .sys_rst_out(so[0]), .irq_pend(ir[0]));

  wdog_keyed #(.ALT_LAYOUT(1'b1), .TICK_CYCLES(TK), .RST_PULSE(RP)) uut_alt (
    .clk(clk), .rst(rst), .bus_addr(ba[1]), .bus_wdata(bd[1]), .bus_wr(bw[1]),
    .bus_rd(br[1]), .bus_rdata(q[1]), .sys_rst_out(so[1]), .irq_pend(ir[1]));

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference state
  int          m_en [2];
  int          m_code [2];
  int          m_act [2];
  int          m_el [2];
  int          m_left [2];
  bit          m_irq [2];
  logic [31:0] m_rd [2];

  function automatic int hs(int c);
    if (c == 0) return 1;
    if (c <= 6) return 2 * c;
    if (c <= 11) return 16 + 4 * (c - 7);
    return 32;
  endfunction

  function automatic int actrl(int L); return L ? 'h00 : 'h10; endfunction
  function automatic int acfg(int L);  return L ? 'h04 : 'h14; endfunction
  function automatic int amode(int L); return L ? 'h04 : 'h18; endfunction

  function automatic logic [31:0] view(int L, int a);
    logic [31:0] v;
    v = '0;
    if (L == 0) begin
      if (a == 'h14) v = m_act[0];
      else if (a == 'h18) v = m_en[0] | (m_code[0] << 4);
    end else begin
      if (a == 'h04) v = m_en[1] | (m_act[1] << 1) | (m_code[1] << 3);
    end
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] d;
    int a, lsb, nen, ncode;
    bit kick, rest, expd, rsel;
    for (int L = 0; L < 2; L++) begin
      if (rst) begin
        m_en[L] = 0; m_code[L] = 0; m_act[L] = 0; m_el[L] = 0;
        m_left[L] = 0; m_irq[L] = 0; m_rd[L] = '0;
      end else begin
        a = ba[L]; d = bd[L];
        lsb = L ? 3 : 4;
        nen = d[0]; ncode = (d >> lsb) & 15;
        kick = bw[L] && a == actrl(L) && d[0] && d[12:1] == 12'hA57;
        rest = kick || (bw[L] && a == amode(L) &&
                        (ncode != m_code[L] || (nen == 1 && m_en[L] == 0)));
        expd = 0;
        if (rest) m_el[L] = 0;
        else if (m_en[L] != 0) begin
          if (m_el[L] + 1 == hs(m_code[L]) * TK) begin expd = 1; m_el[L] = 0; end
          else m_el[L] = m_el[L] + 1;
        end else m_el[L] = 0;
        rsel = (m_act[L] == 1);
        if (expd && rsel) m_left[L] = RP;
        else if (m_left[L] > 0) m_left[L] = m_left[L] - 1;
        if (kick) m_irq[L] = 0;
        else if (expd && !rsel) m_irq[L] = 1;
        if (br[L]) m_rd[L] = view(L, a);
        if (bw[L] && a == amode(L)) begin m_en[L] = nen; m_code[L] = ncode; end
        if (bw[L] && a == acfg(L)) m_act[L] = L ? int'(d[1]) : int'(d[1:0]);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      for (int L = 0; L < 2; L++) begin
        total++;
        if (so[L] !== (m_left[L] != 0)) begin
          bad++;
          $display("FAIL %s/R5 lay%0d cyc%0d sys_rst_out actual=%b expected=%b",
                   cur_req, L, cycles, so[L], m_left[L] != 0);
        end
        total++;
        if (ir[L] !== m_irq[L]) begin
          bad++;
          $display("FAIL %s/R6 lay%0d cyc%0d irq_pend actual=%b expected=%b",
                   cur_req, L, cycles, ir[L], m_irq[L]);
        end
        total++;
        if (q[L] !== m_rd[L]) begin
          bad++;
          $display("FAIL %s/R9 lay%0d cyc%0d bus_rdata actual=%h expected=%h",
                   cur_req, L, cycles, q[L], m_rd[L]);
        end
      end
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int L, int a, logic [31:0] d);
    @(negedge clk);
    ba[L] = a[7:0]; bd[L] = d; bw[L] = 1'b1;
    @(negedge clk);
    bw[L] = 1'b0;
  endtask

  task automatic rdchk(int L, int a, logic [31:0] exp, string tag);
    @(negedge clk);
    ba[L] = a[7:0]; br[L] = 1'b1;
    @(negedge clk);
    br[L] = 1'b0;
    total++;
    if (q[L] !== exp) begin
      bad++;
      $display("FAIL %s lay%0d read %h actual=%h expected=%h", tag, L, a, q[L], exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mv(int L, int en, int code, int rs);
    return L ? (en | (rs << 1) | (code << 3)) : (en | (code << 4));
  endfunction

  localparam logic [31:0] GOOD = {19'd0, 12'hA57, 1'b1};

  task automatic flow(int L);
    int rs;
    cur_req = "R10";
    rdchk(L, amode(L), 32'h0, "R10");
    rdchk(L, acfg(L), 32'h0, "R10");
    rdchk(L, actrl(L), 32'h0, "R10");
    cur_req = L ? "R8" : "R7";
    rs = 1;
    if (L == 0) wr(L, acfg(L), 32'h1);
    cur_req = "R5";
    wr(L, amode(L), mv(L, 1, 0, rs));
    idle(30);
    cur_req = "R3";
    wr(L, amode(L), mv(L, 1, 2, rs));
    idle(40);
    cur_req = "R2";
    idle(5);
    wr(L, actrl(L), {19'd0, 12'hA56, 1'b1});
    wr(L, actrl(L), {19'd0, 12'hA57, 1'b0});
    idle(20);
    cur_req = "R1";
    idle(6); wr(L, actrl(L), GOOD);
    idle(10); wr(L, actrl(L), GOOD);
    idle(30);
    cur_req = "R4";
    idle(3); wr(L, amode(L), mv(L, 1, 2, rs));
    idle(7); wr(L, amode(L), mv(L, 1, 3, rs));
    idle(9); wr(L, amode(L), 32'h0);
    idle(150);
    wr(L, amode(L), mv(L, 1, 1, rs));
    idle(20);
    cur_req = "R6";
    rs = 0;
    if (L == 0) wr(L, acfg(L), 32'h2);
    else wr(L, amode(L), mv(L, 1, 1, rs));
    idle(40);
    wr(L, actrl(L), GOOD);
    idle(3);
    wr(L, actrl(L), {19'd0, 12'h5A7, 1'b1});
    idle(30);
    wr(L, actrl(L), GOOD);
    idle(2);
    cur_req = "R3";
    if (L == 0) wr(L, acfg(L), 32'h1);
    rs = 1;
    for (int c = 0; c < 16; c++) begin
      wr(L, amode(L), mv(L, 1, c, rs));
      idle(hs(c) * TK + 6);
    end
    cur_req = "R9";
    rdchk(L, amode(L), mv(L, 1, 15, rs), "R9");
    if (L == 0) rdchk(L, acfg(L), 32'h1, "R9");
    rdchk(L, actrl(L), 32'h0, "R9");
    rdchk(L, L ? 'h10 : 'h3C, 32'h0, "R9");
    idle(4);
    total++;
    if (q[L] !== view(L, L ? 'h10 : 'h3C)) begin
      bad++;
      $display("FAIL R9 lay%0d hold actual=%h expected=%h", L, q[L], 32'h0);
    end
    wr(L, amode(L), 32'h0);
    idle(40);
  endtask

  initial begin
    for (int L = 0; L < 2; L++) begin
      ba[L] = '0; bd[L] = '0; bw[L] = 1'b0; br[L] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    flow(0);
    flow(1);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule